// File: doc/BRIEF.md
# Folded Systolic FIR Filter

This block is a programmable FIR filter whose taps are folded onto fewer physical
multiply-add elements. Each physical element does the work of FOLD two-tap slots,
so the filter has 2·FOLD·PES taps but only PES element instances. The clock runs
FOLD times faster than the sample rate, and each data period is split into FOLD
clock slots. A slot counter starts on every accepted sample. In slot c, every
element steers sample-history and coefficient pairs for its c-th two-tap slot into
a multiplier pair. The multiplier pair is pipelined STAGES deep, and the element
accumulates FOLD partial sums. The element totals are then added into the filter
output. STAGES may not exceed FOLD; an elaboration error rejects any other setting.

Samples enter on a valid/ready stream and results leave on a valid/ready stream.
`in_ready` depends only on internal state, never on `in_valid`. A sample moves on a
clock edge where both are high. `out_valid`, once raised, stays high with
`out_data` unchanged until a clock edge where `out_ready` is high. A small result
queue absorbs back-pressure. `in_ready` is withheld whenever an accepted sample
could find no room in that queue, so no result is ever dropped. Coefficients are
written through a plain write port.

Top module: `fold_fir`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, every coefficient is 0 and the sample history holds zeros; no output appears before the first accepted sample.
- R2: Each result equals the sum over taps i = 0..TAPS-1 of coef[i]·x[k-i], computed bit-exactly. Here x[k] is the newest accepted sample and x[k-i] the one accepted i samples earlier, zero before reset ended. Data and coefficients are signed two's complement and the result is signed, ACC_W bits wide.
- R3: After an accepted sample, `in_ready` is low for the next FOLD-1 cycles. When the output side is free, a held `in_valid` is accepted exactly every FOLD cycles.
- R4: With an empty result queue and `out_ready` high, `out_valid` rises FOLD+STAGES+1 clock edges after the edge that accepted the sample.
- R5: A write with `coef_we` high sets coef[`coef_addr`] to `coef_data` on a clock edge with no issue window open. A write on any of the FOLD edges that follow an accepted sample is dropped.
- R6: While `out_valid` is high and `out_ready` low, `out_data` stays constant. Results leave in input order. When the queue and the samples in flight fill the capacity, `in_ready` stays low, and no result is lost.
- R7: A sample offered with `in_valid` high while `in_ready` is low is not taken into the history and produces no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, FOLD cycles per data period |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be taken this cycle |
| in_data | input | DATA_W | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(TAPS) | Tap index written |
| coef_data | input | COEF_W | Signed coefficient value |
| out_valid | output | 1 | Filter result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | ACC_W | Signed filter result |

## Verification
The assertions watch, on every cycle, the rules that hold regardless of data. They check that results hold still under back-pressure and that the input goes quiet right after a sample is accepted. They also check that the count of accepted samples not yet delivered never exceeds the queue, and that nothing appears at the output before the first sample. The arithmetic can only be shown by the bench scenarios. Those scenarios cover the impulse response read out tap by tap, the full-negative corner and the exact latency for two pipeline depths. They also show that coefficient writes are dropped inside an issue window and that offers without ready are ignored.

// File: rtl/fold_fir_pkg.sv
package fold_fir_pkg;
  // control tag travelling beside each partial product
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } fold_tag_t;
endpackage

// File: rtl/fold_sched.sv
module fold_sched import fold_fir_pkg::*; #(
  parameter int FOLD = 4,
  parameter int PH_W = (FOLD > 1) ? $clog2(FOLD) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            last_slot,
  output logic [PH_W-1:0] phase,
  output fold_tag_t       tag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      phase <= '0;
    end else if (busy) begin
      if (phase == PH_W'(FOLD - 1)) busy <= 1'b0;
      else                          phase <= phase + 1'b1;
    end
  end

  assign last_slot = busy && (phase == PH_W'(FOLD - 1));
  assign tag.vld   = busy;
  assign tag.first = busy && (phase == '0);
  assign tag.last  = last_slot;
endmodule

// File: rtl/fold_pe.sv
module fold_pe import fold_fir_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 21,
  parameter int FOLD   = 4,
  parameter int STAGES = 1,
  parameter int PH_W   = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [2*FOLD-1:0][DATA_W-1:0]      xs,
  input  logic [2*FOLD-1:0][COEF_W-1:0]      cs,
  input  logic [PH_W-1:0]                    phase,
  input  fold_tag_t                          tag,
  output logic signed [ACC_W-1:0]            total,
  output logic                               total_vld
);
  localparam int PW = DATA_W + COEF_W;

  // FOLD-to-1 selectors for both multipliers
  logic [PH_W:0] sel_a, sel_b;
  assign sel_a = {phase, 1'b0};
  assign sel_b = {phase, 1'b1};

  logic signed [DATA_W-1:0] xa, xb;
  logic signed [COEF_W-1:0] ca, cb;
  assign xa = xs[sel_a];
  assign xb = xs[sel_b];
  assign ca = cs[sel_a];
  assign cb = cs[sel_b];

  logic signed [PW-1:0]    pa, pb;
  logic signed [ACC_W-1:0] pair;
  assign pa   = xa * ca;
  assign pb   = xb * cb;
  assign pair = $signed({{(ACC_W-PW){pa[PW-1]}}, pa})
              + $signed({{(ACC_W-PW){pb[PW-1]}}, pb});

  // STAGES-deep datapath with matching tag delay line
  logic signed [ACC_W-1:0] stg [STAGES];
  fold_tag_t               tg  [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) begin
        stg[k] <= '0;
        tg[k]  <= '0;
      end
    end else begin
      stg[0] <= pair;
      tg[0]  <= tag;
      for (int k = 1; k < STAGES; k++) begin
        stg[k] <= stg[k-1];
        tg[k]  <= tg[k-1];
      end
    end
  end

  // accumulator input selector: restart on first slot, otherwise add
  logic signed [ACC_W-1:0] acc, acc_in, acc_nx;
  assign acc_in = tg[STAGES-1].first ? '0 : acc;
  assign acc_nx = acc_in + stg[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      total     <= '0;
      total_vld <= 1'b0;
    end else begin
      total_vld <= tg[STAGES-1].vld && tg[STAGES-1].last;
      if (tg[STAGES-1].vld) acc <= acc_nx;
      if (tg[STAGES-1].vld && tg[STAGES-1].last) total <= acc_nx;
    end
  end
endmodule

// File: rtl/fold_fifo.sv
module fold_fifo #(
  parameter int W    = 21,
  parameter int D    = 3,
  parameter int PW   = (D > 1) ? $clog2(D) : 1,
  parameter int CN_W = $clog2(D + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    dout,
  output logic            empty,
  output logic [CN_W-1:0] count
);
  logic [W-1:0]    mem [D];
  logic [PW-1:0]   wp, rp;
  logic [CN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(D - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(D - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CN_W'(push) - CN_W'(pop);
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign count = cnt;
endmodule

// File: rtl/fold_fir.sv
module fold_fir import fold_fir_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int FOLD   = 4,
  parameter int STAGES = 1,
  parameter int PES    = 2,
  parameter int TAPS   = 2 * FOLD * PES,
  parameter int ADDR_W = $clog2(TAPS),
  parameter int ACC_W  = DATA_W + COEF_W + $clog2(TAPS) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DATA_W-1:0]        in_data,
  input  logic                     coef_we,
  input  logic [ADDR_W-1:0]        coef_addr,
  input  logic [COEF_W-1:0]        coef_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [ACC_W-1:0]         out_data
);
  localparam int PH_W   = (FOLD > 1) ? $clog2(FOLD) : 1;
  localparam int LAT    = FOLD + STAGES + 1;
  localparam int QDEPTH = (LAT + FOLD - 1) / FOLD + 1;
  localparam int CN_W   = $clog2(QDEPTH + 1);

  generate
    if (STAGES < 1 || STAGES > FOLD) begin : g_bad_cfg
      $error("fold_fir: STAGES must lie in 1..FOLD");
    end
  endgenerate

  logic            busy, last_slot, accept, push, pop, q_empty;
  logic [PH_W-1:0] phase;
  fold_tag_t       tag;
  logic [CN_W-1:0] pending, q_count;

  assign accept = in_valid && in_ready;
  assign in_ready = (!busy || last_slot) && ((pending + q_count) < CN_W'(QDEPTH));

  fold_sched #(.FOLD(FOLD), .PH_W(PH_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .busy(busy), .last_slot(last_slot), .phase(phase), .tag(tag)
  );

  logic [TAPS-1:0][DATA_W-1:0] hist;
  logic [TAPS-1:0][COEF_W-1:0] coefs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist  <= '0;
      coefs <= '0;
    end else begin
      if (accept)             hist <= {hist[TAPS-2:0], in_data};
      if (coef_we && !busy)   coefs[coef_addr] <= coef_data;
    end
  end

  logic signed [ACC_W-1:0] totals [PES];
  logic [PES-1:0]          tot_vld;

  for (genvar g = 0; g < PES; g++) begin : g_pe
    fold_pe #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
      .FOLD(FOLD), .STAGES(STAGES), .PH_W(PH_W)
    ) u_pe (
      .clk(clk), .rst_n(rst_n),
      .xs(hist[g*2*FOLD +: 2*FOLD]),
      .cs(coefs[g*2*FOLD +: 2*FOLD]),
      .phase(phase), .tag(tag),
      .total(totals[g]), .total_vld(tot_vld[g])
    );
  end

  logic signed [ACC_W-1:0] sum;
  always_comb begin
    sum = '0;
    for (int g = 0; g < PES; g++) sum = sum + totals[g];
  end

  assign push = &tot_vld;
  assign pop  = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pending <= '0;
    else if (accept && !push)  pending <= pending + 1'b1;
    else if (push && !accept)  pending <= pending - 1'b1;
  end

  fold_fifo #(.W(ACC_W), .D(QDEPTH), .CN_W(CN_W)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push), .din(sum),
    .pop(pop), .dout(out_data), .empty(q_empty), .count(q_count)
  );

  assign out_valid = !q_empty;
endmodule

// File: rtl/fold_fir_chk.sv
module fold_fir_chk #(
  parameter int FOLD = 4,
  parameter int OW   = 21,
  parameter int QD   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data
);
  int   outstanding;
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 0;
      seen        <= 1'b0;
    end else begin
      outstanding <= outstanding + int'(in_valid && in_ready) - int'(out_valid && out_ready);
      if (in_valid && in_ready) seen <= 1'b1;
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R3
  rate_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (FOLD > 1)) |=> !in_ready);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= QD);

  // R1
  quiet_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !out_valid);
endmodule

bind fold_fir fold_fir_chk #(.FOLD(FOLD), .OW(ACC_W), .QD(QDEPTH)) u_fold_fir_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/test_fold_fir.sv
module test_fold_fir;
  localparam int FOLD = 4;
  localparam int PES  = 2;
  localparam int TAPS = 2 * FOLD * PES;
  localparam int NTAB = 18;
  // impulse of 3 then zeros, with coef[i] = i - 5
  localparam int TAB_X [NTAB] = '{3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, -128};
  localparam int TAB_Y [NTAB] = '{-15, -12, -9, -6, -3, 0, 3, 6, 9, 12, 15, 18, 21, 24, 27, 30, 0, 640};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              in_valid = 1'b0, out_ready = 1'b1, coef_we = 1'b0;
  logic signed [7:0] in_data = '0, coef_data = '0;
  logic [3:0]        coef_addr = '0;
  logic              rdy_a, rdy_b, va, vb;
  logic signed [20:0] da, db;

  fold_fir #(.FOLD(FOLD), .STAGES(1), .PES(PES)) i_fold_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a), .in_data(in_data),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .out_valid(va), .out_ready(out_ready), .out_data(da));

  fold_fir #(.FOLD(FOLD), .STAGES(2), .PES(PES)) i_fold_fir_deep (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b), .in_data(in_data),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .out_valid(vb), .out_ready(out_ready), .out_data(db));

  int n_chk = 0, n_err = 0, cyc = 0;
  int mhist [TAPS];
  int mcoef [TAPS];
  int exp_q [256];
  int wr = 0, rd_a = 0, rd_b = 0;
  int acc_edge = 0;
  string cur_req = "R2";
  logic stall_a = 1'b0, stall_b = 1'b0;
  logic signed [20:0] hold_a, hold_b;

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected fewer cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // scoreboard and stall monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_a) check("R6", int'(da), int'(hold_a));
      if (stall_b) check("R6", int'(db), int'(hold_b));
      if (va && out_ready) begin check(cur_req, int'(da), exp_q[rd_a]); rd_a++; end
      if (vb && out_ready) begin check(cur_req, int'(db), exp_q[rd_b]); rd_b++; end
      stall_a = va && !out_ready; hold_a = da;
      stall_b = vb && !out_ready; hold_b = db;
    end
  end

  function automatic int model_push(input int x);
    int s = 0;
    for (int i = TAPS - 1; i > 0; i--) mhist[i] = mhist[i-1];
    mhist[0] = x;
    for (int i = 0; i < TAPS; i++) s += mhist[i] * mcoef[i];
    return s;
  endfunction

  // called at posedge+1; returns at posedge+1 after the accepting edge
  task automatic send(input int x, input bit use_tab, input int tab_y);
    int m;
    in_valid = 1'b1;
    in_data  = 8'(x);
    forever begin
      @(negedge clk);
      if (rdy_a) begin
        acc_edge = cyc + 1;
        m = model_push(x);
        exp_q[wr] = use_tab ? tab_y : m;
        wr++;
        @(posedge clk); #1;
        in_valid = 1'b0;
        break;
      end
      @(posedge clk); #1;
    end
  endtask

  task automatic wcoef(input int a, input int v, input bit applied);
    coef_we = 1'b1; coef_addr = 4'(a); coef_data = 8'(v);
    @(posedge clk); #1;
    coef_we = 1'b0;
    if (applied) mcoef[a] = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic drain;
    for (int i = 0; i < 300; i++) begin
      if (rd_a == wr && rd_b == wr) break;
      @(posedge clk); #1;
    end
    idle(2);
  endtask

  initial begin
    int lat_a, lat_b, prev_edge, n_acc;
    for (int i = 0; i < TAPS; i++) begin mhist[i] = 0; mcoef[i] = 0; end
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", int'(rdy_a), 1);
    check("R1", int'(va), 0);
    check("R1", int'(vb), 0);
    @(posedge clk); #1;

    // R1: all-zero coefficients after reset give zero result
    cur_req = "R1";
    send(9, 1'b0, 0);
    drain();
    check("R1", exp_q[0], 0);
    // return history to zero for the table
    for (int i = 0; i < TAPS; i++) send(0, 1'b0, 0);
    drain();

    for (int i = 0; i < TAPS; i++) wcoef(i, i - 5, 1'b1);
    idle(2);

    // R2 table walk, back to back
    cur_req = "R2";
    for (int t = 0; t < NTAB; t++) send(TAB_X[t], 1'b1, TAB_Y[t]);
    drain();

    // R4 latency on both pipeline depths
    cur_req = "R4";
    send(5, 1'b0, 0);
    lat_a = -1; lat_b = -1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (va && lat_a < 0) lat_a = cyc - acc_edge;
      if (vb && lat_b < 0) lat_b = cyc - acc_edge;
    end
    check("R4", lat_a, FOLD + 2);
    check("R4", lat_b, FOLD + 3);
    @(posedge clk); #1;
    drain();

    // R3 accept spacing with valid held
    cur_req = "R3";
    send(11, 1'b0, 0);
    prev_edge = acc_edge;
    for (int k = 0; k < 4; k++) begin
      send(-20 + 7 * k, 1'b0, 0);
      check("R3", acc_edge - prev_edge, FOLD);
      prev_edge = acc_edge;
    end
    drain();

    // R7 offers without ready are ignored
    cur_req = "R7";
    send(4, 1'b0, 0);
    in_valid = 1'b1; in_data = 8'd77;
    @(negedge clk);
    check("R7", int'(rdy_a), 0);
    @(posedge clk); #1;
    @(negedge clk);
    check("R7", int'(rdy_a), 0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    drain();
    send(-3, 1'b0, 0);
    drain();
    check("R7", rd_a, wr);

    // R5 write inside issue window dropped, idle write applied
    cur_req = "R5";
    send(6, 1'b0, 0);
    wcoef(0, 50, 1'b0);
    drain();
    wcoef(1, -7, 1'b1);
    send(2, 1'b0, 0);
    send(-9, 1'b0, 0);
    drain();

    // R2 corner: most negative operands everywhere
    cur_req = "R2";
    for (int i = 0; i < TAPS; i++) wcoef(i, -128, 1'b1);
    for (int i = 0; i < TAPS; i++) send(-128, 1'b0, 0);
    drain();
    check("R2", exp_q[wr-1], 262144);

    // R6 back-pressure fill then release
    cur_req = "R6";
    out_ready = 1'b0;
    n_acc = 0;
    in_valid = 1'b1; in_data = 8'd13;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rdy_a) begin
        exp_q[wr] = model_push(int'(in_data));
        wr++;
        n_acc++;
        @(posedge clk); #1;
        in_data = in_data + 8'sd17;
      end else begin
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R6", int'(rdy_a), 0);
    check("R6", int'(va), 1);
    check("R6", int'(n_acc > 0), 1);
    @(posedge clk); #1;
    out_ready = 1'b1;
    drain();
    check("R6", rd_b, wr);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule